// File: doc/BRIEF.md
# Interrupt Cycle Statistics Unit

This block profiles interrupt service routines by counting clock cycles. Two single-cycle strobes come from outside: one marks the start of a routine and one marks its return. A per-cycle `tick` qualifies which cycles are counted. For every completed routine the block updates the shortest and the longest duration seen, the number of completed routines, and the sum of all routine durations. It then recomputes the mean duration. The mean is the sum divided by the count. It is not the midpoint of the extremes.

Every statistic is visible at all times on its own output port. The mean comes from a shift-and-subtract divider that runs one bit per clock after each completed routine. A one-cycle `avg_valid` pulse marks each fresh result. A synchronous `clr` puts all statistics back to their starting values.

A duration tracker FSM has the states TRK_IDLE and TRK_OPEN. The transition TRK_IDLE→TRK_OPEN happens on `isr_enter`. The transition TRK_OPEN→TRK_IDLE happens on `isr_exit`. `clr` forces TRK_IDLE from either state. The divider FSM has the states DIV_IDLE and DIV_RUN. The transition DIV_IDLE→DIV_RUN happens on a start request. DIV_RUN repeats itself when a new start request arrives. DIV_RUN→DIV_IDLE happens after the last quotient bit. `clr` forces DIV_IDLE from either state.

Top module: `isr_cycle_stats`

## Requirements
- R1: After reset and after `clr`: `min_cyc` is all ones, `max_cyc` is 0, `call_cnt` is 0, `total_cyc` is 0, `avg_cyc` is 0 and `avg_valid` is low.
- R2: The duration of a routine is the number of cycles with `tick` high. Counting starts in the cycle after the accepted entry strobe and includes the cycle in which `isr_exit` is sampled. A tick in the entry cycle is not counted.
- R3: An `isr_exit` while no routine is open changes no statistic and produces no `avg_valid`. An `isr_enter` while a routine is open neither restarts nor ends the count.
- R4: After each completed routine, `min_cyc` and `max_cyc` hold the smallest and the largest durations completed since the last reset or clear.
- R5: `call_cnt` (width CALL_W, default 24) increments by one per completed routine and holds at all ones instead of wrapping.
- R6: `total_cyc` (width TOT_W, default 40) adds each duration and holds at all ones instead of wrapping.
- R7: A routine duration (width CYC_W, default 16) saturates at all ones.
- R8: After each completed routine, `avg_cyc` becomes floor(`total_cyc` / `call_cnt`) of the updated statistics. It is not (min+max)/2. The result is flagged by a one-cycle `avg_valid` pulse no more than TOT_W+4 cycles after the exit cycle, and `avg_cyc` holds its value between pulses.
- R9: `clr` takes priority. An exit sampled together with `clr` is dropped. An open routine is closed. A division in progress is abandoned and produces no `avg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of all statistics |
| tick | input | 1 | Counted-cycle qualifier |
| isr_enter | input | 1 | Routine start strobe |
| isr_exit | input | 1 | Routine return strobe |
| min_cyc | output | CYC_W | Shortest completed duration |
| max_cyc | output | CYC_W | Longest completed duration |
| call_cnt | output | CALL_W | Completed routine count |
| total_cyc | output | TOT_W | Sum of all durations |
| avg_cyc | output | TOT_W | Mean duration |
| avg_valid | output | 1 | One-cycle pulse on a fresh mean |

## Verification
Several events can fall in the same cycle, and each such collision is provoked on purpose. A tick can coincide with the exit strobe, and the bench checks that the tick is counted. A second entry can coincide with an open routine, and the bench checks that the count carries on instead of restarting. A clear can coincide with an exit, and the bench drives both in one cycle and checks that the count stays zero. A clear can also arrive while a division is running, and the bench checks that no valid pulse follows. Each verdict is judged only at the ports, against statistics the bench recomputes arithmetically. Those expected values come from a small configuration in which every saturation point is reached.

// File: rtl/isr_stats_pkg.sv
package isr_stats_pkg;
    typedef enum logic {TRK_IDLE, TRK_OPEN} trk_state_e;
    typedef enum logic {DIV_IDLE, DIV_RUN} div_state_e;
endpackage

// File: rtl/isr_dur_tracker.sv
module isr_dur_tracker
    import isr_stats_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             isr_enter,
    input  logic             isr_exit,
    output logic             dur_vld,
    output logic [CYC_W-1:0] dur_val
);
    localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

    trk_state_e       state_q, state_d;
    logic [CYC_W-1:0] cnt_q, cnt_inc;

    assign cnt_inc = (tick && cnt_q != CYC_MAX) ? cnt_q + 1'b1 : cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (isr_enter) state_d = TRK_OPEN;
            TRK_OPEN: if (isr_exit)  state_d = TRK_IDLE;
        endcase
        if (clr) state_d = TRK_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dur_vld <= 1'b0;
            dur_val <= '0;
        end else begin
            dur_vld <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    TRK_IDLE: if (isr_enter) cnt_q <= '0;
                    TRK_OPEN: begin
                        cnt_q <= cnt_inc;
                        if (isr_exit) begin
                            dur_vld <= 1'b1;
                            dur_val <= cnt_inc;
                        end
                    end
                endcase
            end
        end
    end

    AST_STRAY_EXIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE && isr_exit) |=> !dur_vld); // R3
    AST_DUR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_OPEN && !clr && !isr_exit && cnt_q == CYC_MAX) |=> cnt_q == CYC_MAX); // R7
    AST_CLR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == TRK_IDLE && !dur_vld)); // R9
endmodule

// File: rtl/isr_stat_accum.sv
module isr_stat_accum #(
    parameter int CYC_W  = 16,
    parameter int CALL_W = 24,
    parameter int TOT_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dur_vld,
    input  logic [CYC_W-1:0]  dur_val,
    output logic [CYC_W-1:0]  min_cyc,
    output logic [CYC_W-1:0]  max_cyc,
    output logic [CALL_W-1:0] call_cnt,
    output logic [TOT_W-1:0]  total_cyc,
    output logic              div_start
);
    localparam logic [CALL_W-1:0] CALL_MAX = {CALL_W{1'b1}};
    localparam logic [TOT_W-1:0]  TOT_MAX  = {TOT_W{1'b1}};

    logic [TOT_W:0] sum_ext;
    assign sum_ext = {1'b0, total_cyc} + (TOT_W+1)'(dur_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_cyc   <= '1;
            max_cyc   <= '0;
            call_cnt  <= '0;
            total_cyc <= '0;
            div_start <= 1'b0;
        end else begin
            div_start <= dur_vld && !clr;
            if (clr) begin
                min_cyc   <= '1;
                max_cyc   <= '0;
                call_cnt  <= '0;
                total_cyc <= '0;
            end else if (dur_vld) begin
                if (dur_val < min_cyc) min_cyc <= dur_val;
                if (dur_val > max_cyc) max_cyc <= dur_val;
                if (call_cnt != CALL_MAX) call_cnt <= call_cnt + 1'b1;
                total_cyc <= sum_ext[TOT_W] ? TOT_MAX : sum_ext[TOT_W-1:0];
            end
        end
    end

    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (call_cnt != '0) |-> (min_cyc <= max_cyc)); // R4
    AST_CALLS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && call_cnt == CALL_MAX) |=> call_cnt == CALL_MAX); // R5
    AST_TOTAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> total_cyc >= $past(total_cyc)); // R6
endmodule

// File: rtl/isr_seq_divider.sv
module isr_seq_divider
    import isr_stats_pkg::*;
#(
    parameter int NUM_W = 40,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             vld
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    div_state_e        state_q, state_d;
    logic [DEN_W:0]    rem_q, rem_sh, rem_nx;
    logic [NUM_W-1:0]  q_q, q_nx;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              fits, last;

    assign rem_sh = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
    assign fits   = rem_sh >= {1'b0, den_q};
    assign rem_nx = fits ? rem_sh - {1'b0, den_q} : rem_sh;
    assign q_nx   = {q_q[NUM_W-2:0], fits};
    assign last   = step_q == STEP_W'(NUM_W - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (start) state_d = DIV_RUN;
            DIV_RUN:  if (last && !start) state_d = DIV_IDLE;
        endcase
        if (clr) state_d = DIV_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0; q_q <= '0; den_q <= '0; step_q <= '0;
            quo   <= '0; vld <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (clr) begin
                quo <= '0;
            end else if (start) begin
                rem_q  <= '0;
                q_q    <= num;
                den_q  <= den;
                step_q <= '0;
            end else if (state_q == DIV_RUN) begin
                rem_q  <= rem_nx;
                q_q    <= q_nx;
                step_q <= step_q + 1'b1;
                if (last) begin
                    quo <= q_nx;
                    vld <= 1'b1;
                end
            end
        end
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr) |=> state_q == DIV_RUN); // R8
    AST_VLD_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(state_q) == DIV_RUN); // R8
    AST_CLR_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !vld); // R9
endmodule

// File: rtl/isr_cycle_stats.sv
module isr_cycle_stats #(
    parameter int CYC_W  = 16,
    parameter int CALL_W = 24,
    parameter int TOT_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              isr_enter,
    input  logic              isr_exit,
    output logic [CYC_W-1:0]  min_cyc,
    output logic [CYC_W-1:0]  max_cyc,
    output logic [CALL_W-1:0] call_cnt,
    output logic [TOT_W-1:0]  total_cyc,
    output logic [TOT_W-1:0]  avg_cyc,
    output logic              avg_valid
);
    logic             dur_vld, div_start;
    logic [CYC_W-1:0] dur_val;

    isr_dur_tracker #(.CYC_W(CYC_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .isr_enter(isr_enter), .isr_exit(isr_exit),
        .dur_vld(dur_vld), .dur_val(dur_val)
    );

    isr_stat_accum #(.CYC_W(CYC_W), .CALL_W(CALL_W), .TOT_W(TOT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .dur_vld(dur_vld), .dur_val(dur_val),
        .min_cyc(min_cyc), .max_cyc(max_cyc), .call_cnt(call_cnt),
        .total_cyc(total_cyc), .div_start(div_start)
    );

    isr_seq_divider #(.NUM_W(TOT_W), .DEN_W(CALL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(div_start),
        .num(total_cyc), .den(call_cnt), .quo(avg_cyc), .vld(avg_valid)
    );

    AST_AVG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_valid && !clr) |=> (avg_valid || $stable(avg_cyc) || $past(clr))); // R8
endmodule

// File: tb/test_isr_cycle_stats.sv
module test_isr_cycle_stats;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 5, NW = 4, TW = 8;
    localparam longint CMAX = (1 << CW) - 1;
    localparam longint NMAX = (1 << NW) - 1;
    localparam longint TMAX = (1 << TW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, tick = 1'b0, ent = 1'b0, ext = 1'b0;
    logic [CW-1:0] min_cyc, max_cyc;
    logic [NW-1:0] call_cnt;
    logic [TW-1:0] total_cyc, avg_cyc;
    logic avg_valid;

    int checks = 0, errors = 0, vld_seen = 0;
    longint e_min = CMAX, e_max = 0, e_cnt = 0, e_tot = 0, e_avg = 0;

    isr_cycle_stats #(.CYC_W(CW), .CALL_W(NW), .TOT_W(TW)) i_isr_cycle_stats (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .isr_enter(ent), .isr_exit(ext),
        .min_cyc(min_cyc), .max_cyc(max_cyc), .call_cnt(call_cnt),
        .total_cyc(total_cyc), .avg_cyc(avg_cyc), .avg_valid(avg_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (avg_valid) vld_seen++;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "min", longint'(min_cyc), e_min);
        chk(req, "max", longint'(max_cyc), e_max);
        chk(req, "calls", longint'(call_cnt), e_cnt);
        chk(req, "total", longint'(total_cyc), e_tot);
        chk(req, "avg", longint'(avg_cyc), e_avg);
    endtask

    task automatic model_clear();
        e_min = CMAX; e_max = 0; e_cnt = 0; e_tot = 0; e_avg = 0;
    endtask

    task automatic model_add(input longint d);
        if (d < e_min) e_min = d;
        if (d > e_max) e_max = d;
        if (e_cnt < NMAX) e_cnt++;
        e_tot = (e_tot + d > TMAX) ? TMAX : e_tot + d;
        e_avg = e_tot / e_cnt;
    endtask

    task automatic wait_valid(input string req);
        int w = 0;
        while (!avg_valid && w < TW + 8) begin @(negedge clk); w++; end
        chk(req, "valid latency ok", longint'(avg_valid && w <= TW + 4), 1);
    endtask

    // one routine: n cycles after entry, tick when (i % k)==0, exit on last
    task automatic run_isr(input int n, input int k, input string req);
        longint d = 0;
        @(negedge clk); ent = 1'b1; tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ent = 1'b0;
            tick = ((i % k) == 0);
            ext  = (i == n - 1);
            if (tick) d++;
        end
        @(negedge clk); ext = 1'b0; tick = 1'b0;
        if (d > CMAX) d = CMAX;
        model_add(d);
        wait_valid(req);
        chk_all(req);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_clear();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        chk_all("R1 reset");
        chk("R1", "valid low", longint'(avg_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: stray exit with tick
        v0 = vld_seen;
        ext = 1'b1; tick = 1'b1;
        @(negedge clk); ext = 1'b0; tick = 1'b0;
        repeat (TW + 6) @(negedge clk);
        chk_all("R3 stray exit");
        chk("R3", "no valid", vld_seen - v0, 0);

        // R8: mean is total/count, not midpoint
        run_isr(3, 1, "R4");
        run_isr(3, 1, "R4");
        run_isr(3, 1, "R4");
        run_isr(25, 1, "R8");
        chk("R8", "avg is 34/4", longint'(avg_cyc), 8);
        @(negedge clk);
        chk("R8", "avg held", longint'(avg_cyc), 8);

        do_clear();
        chk_all("R1 after clear");

        // R7 R5 R6: sweep across every saturation point
        for (int n = 1; n <= 36; n++) run_isr(n, 1, "R7 R5 R6 sweep");
        chk("R5", "calls saturated", longint'(call_cnt), NMAX);
        chk("R6", "total saturated", longint'(total_cyc), TMAX);
        chk("R7", "max saturated", longint'(max_cyc), CMAX);

        // R2: sparse tick patterns, entry-cycle tick not counted
        do_clear();
        for (int k = 2; k <= 3; k++)
            for (int n = 1; n <= 7; n++) run_isr(n, k, "R2");

        // R3: re-entry while open does not restart
        do_clear();
        @(negedge clk); ent = 1'b1; tick = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            ent = (i == 3);
            ext = (i == 6);
        end
        @(negedge clk); ent = 1'b0; ext = 1'b0; tick = 1'b0;
        model_add(7);
        wait_valid("R3 nested");
        chk_all("R3 nested");

        // R9: clear together with exit drops the routine
        do_clear();
        v0 = vld_seen;
        @(negedge clk); ent = 1'b1; tick = 1'b1;
        @(negedge clk); ent = 1'b0;
        @(negedge clk); ext = 1'b1; clr = 1'b1;
        @(negedge clk); ext = 1'b0; clr = 1'b0; tick = 1'b0;
        repeat (TW + 6) @(negedge clk);
        chk_all("R9 clr+exit");
        chk("R9", "no valid", vld_seen - v0, 0);
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        repeat (TW + 6) @(negedge clk);
        chk_all("R9 routine closed");

        // R9: clear during division
        run_isr(4, 1, "R2");
        @(negedge clk); ent = 1'b1; tick = 1'b1;
        @(negedge clk); ent = 1'b0; ext = 1'b1;
        @(negedge clk); ext = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        v0 = vld_seen;
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        model_clear();
        repeat (TW + 6) @(negedge clk);
        chk("R9", "no valid after abort", vld_seen - v0, 0);
        chk_all("R9 abort");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule